// File: doc/BRIEF.md
# AC'97 Codec Control-Slot Access Engine

This block carries control traffic between a host and an external AC'97 codec over the command and status slots (slots 1 and 2) of the AC-link frame. The host loads a command-address word and a command-data word into two holding registers. At the next frame boundary the block places the held words into the outgoing frame, marks them valid in the outgoing tag, and drops the matching busy flag. Loading the address word is what arms a transfer, so for a register write the data word is loaded first. A read request is an address word with its read bit set; the codec answers some frames later.

On the receive side, the block watches each incoming frame. When the tag marks slot 1 or slot 2 valid and that receive direction is enabled, it latches the slot word and raises a valid flag. A read strobe from the host empties the register by clearing the flag. A set of main control inputs enables the interface, enables each slot direction separately and selects which of up to four codecs the outgoing frame addresses. The serializer that shifts frames onto the wire sits outside this block and exchanges whole slot words with it through frame strobes.

Top module: `ac97_regacc`

## Requirements
- R1: During and after reset, with no stimulus, both busy flags, both valid flags, both outgoing tag bits, the codec field and all slot words read 0.
- R2: With the interface enabled, a command-address load sets slot 1 busy and a command-data load sets slot 2 busy in the next cycle; each flag stays high until its word is sent.
- R3: At a frame strobe with the interface enabled, slot 1 busy and slot 1 transmit enabled, the next cycle shows outgoing tag bit 0 set, the held slot 1 word unchanged on the slot 1 output and slot 1 busy low. Slot 1 words carry the read flag in bit 19 and the register index in bits 18:12; slot 2 words carry the 16-bit data in bits 19:4. The block forwards both unchanged.
- R4: Slot 2 is sent (tag bit 1 set, busy cleared) only in a frame in which slot 1 is also sent and only when slot 2 is busy and its transmit enable is set; otherwise slot 2 stays busy and is not sent.
- R5: A slot whose transmit enable is low is never sent and keeps its busy flag.
- R6: The outgoing tag bits, slot words and codec field change only in the cycle after a frame strobe; a slot not sent in that frame shows tag bit 0 and a zero word.
- R7: At an incoming frame strobe with the interface enabled, a slot whose receive enable and incoming tag bit (bit 0 slot 1, bit 1 slot 2) are both set is latched and its valid flag is high in the next cycle.
- R8: A slot whose receive enable or incoming tag bit is low is not latched: its status word and valid flag keep their values.
- R9: A read strobe clears that slot's valid flag in the next cycle and leaves its status word; if a capture happens in the same cycle the flag stays high with the new word.
- R10: A new capture overwrites a status word that has not been read.
- R11: A command load in the same cycle as the frame strobe that sends the slot sends the old word, keeps the new one and leaves the busy flag high.
- R12: While the interface enable is low, all busy and valid flags read 0 from the next cycle, loads and captures set no flag and no slot is sent.
- R13: The outgoing codec field takes the codec select value (2 bits, codecs 0 to 3) at every frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_en_i | input | 1 | Interface enable |
| codec_sel_i | input | 2 | Target codec number |
| slot_tx_en_i | input | 2 | Transmit enable, bit 0 slot 1, bit 1 slot 2 |
| slot_rx_en_i | input | 2 | Receive enable, bit 0 slot 1, bit 1 slot 2 |
| cmd_addr_we_i | input | 1 | Load strobe for the command-address word |
| cmd_addr_i | input | 20 | Command-address word |
| cmd_data_we_i | input | 1 | Load strobe for the command-data word |
| cmd_data_i | input | 20 | Command-data word |
| sts_addr_re_i | input | 1 | Read strobe for the status-address register |
| sts_data_re_i | input | 1 | Read strobe for the status-data register |
| sts_addr_o | output | 20 | Latched status-address word |
| sts_data_o | output | 20 | Latched status-data word |
| tx_busy_o | output | 2 | Transmit busy, bit 0 slot 1, bit 1 slot 2 |
| rx_valid_o | output | 2 | Receive valid, bit 0 slot 1, bit 1 slot 2 |
| frame_start_i | input | 1 | Outgoing frame boundary strobe |
| tx_tag_o | output | 2 | Outgoing tag valid bits for slots 1 and 2 |
| tx_codec_o | output | 2 | Outgoing codec number |
| tx_slot1_o | output | 20 | Outgoing slot 1 word |
| tx_slot2_o | output | 20 | Outgoing slot 2 word |
| rx_frame_i | input | 1 | Incoming frame strobe |
| rx_tag_i | input | 2 | Incoming tag valid bits for slots 1 and 2 |
| rx_slot1_i | input | 20 | Incoming slot 1 word |
| rx_slot2_i | input | 20 | Incoming slot 2 word |

## Verification
Every result of this block is due exactly one cycle after the edge that samples its cause: a load sets busy, a frame strobe updates the outgoing tag, words and codec field and clears busy, an incoming frame sets valid and the status word, a read strobe clears valid, and a drop of the interface enable clears every flag. The bench keeps a behavioural model that advances on the same rising edge from the same inputs and compares all outputs at each falling edge, so a result that arrives a cycle early or late shows as a mismatch. Stimulus covers the collisions named in the requirements: a load on the frame edge, a capture with a read strobe, gated slots and the interface disabled.

// File: rtl/ac97_regacc_pkg.sv
package ac97_regacc_pkg;
  localparam int SLOT_W  = 20;
  localparam int N_SLOTS = 2;
  typedef logic [SLOT_W-1:0] slot_word_t;
endpackage

// File: rtl/ac97_regacc_txslot.sv
module ac97_regacc_txslot
  import ac97_regacc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       load_i,
  input  slot_word_t wdata_i,
  input  logic       send_i,
  output slot_word_t hold_o,
  output logic       busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= '0;
      busy_o <= 1'b0;
    end else begin
      if (load_i) hold_o <= wdata_i;
      // set wins over send: new word must still go out
      if (clr_i)       busy_o <= 1'b0;
      else if (load_i) busy_o <= 1'b1;
      else if (send_i) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ac97_regacc_rxslot.sv
module ac97_regacc_rxslot
  import ac97_regacc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       cap_i,
  input  slot_word_t din_i,
  input  logic       rd_i,
  output slot_word_t data_o,
  output logic       valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (cap_i) data_o <= din_i;
      if (clr_i)      valid_o <= 1'b0;
      else if (cap_i) valid_o <= 1'b1;
      else if (rd_i)  valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ac97_regacc.sv
module ac97_regacc
  import ac97_regacc_pkg::*;
#(
  parameter int NUM_CODECS = 4,
  localparam int CID_W = (NUM_CODECS > 1) ? $clog2(NUM_CODECS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              if_en_i,
  input  logic [CID_W-1:0]  codec_sel_i,
  input  logic [N_SLOTS-1:0] slot_tx_en_i,
  input  logic [N_SLOTS-1:0] slot_rx_en_i,
  input  logic              cmd_addr_we_i,
  input  logic [SLOT_W-1:0] cmd_addr_i,
  input  logic              cmd_data_we_i,
  input  logic [SLOT_W-1:0] cmd_data_i,
  input  logic              sts_addr_re_i,
  input  logic              sts_data_re_i,
  output logic [SLOT_W-1:0] sts_addr_o,
  output logic [SLOT_W-1:0] sts_data_o,
  output logic [N_SLOTS-1:0] tx_busy_o,
  output logic [N_SLOTS-1:0] rx_valid_o,
  input  logic              frame_start_i,
  output logic [N_SLOTS-1:0] tx_tag_o,
  output logic [CID_W-1:0]  tx_codec_o,
  output logic [SLOT_W-1:0] tx_slot1_o,
  output logic [SLOT_W-1:0] tx_slot2_o,
  input  logic              rx_frame_i,
  input  logic [N_SLOTS-1:0] rx_tag_i,
  input  logic [SLOT_W-1:0] rx_slot1_i,
  input  logic [SLOT_W-1:0] rx_slot2_i
);
  logic [N_SLOTS-1:0] ld, rd, send, cap;
  slot_word_t wdat [N_SLOTS];
  slot_word_t hold [N_SLOTS];
  slot_word_t rxd  [N_SLOTS];
  slot_word_t capd [N_SLOTS];
  logic launch;

  assign ld      = {cmd_data_we_i, cmd_addr_we_i};
  assign rd      = {sts_data_re_i, sts_addr_re_i};
  assign wdat[0] = cmd_addr_i;
  assign wdat[1] = cmd_data_i;
  assign rxd[0]  = rx_slot1_i;
  assign rxd[1]  = rx_slot2_i;

  // slot 1 arms the frame; slot 2 only rides along
  assign launch  = frame_start_i & if_en_i & tx_busy_o[0] & slot_tx_en_i[0];
  assign send[0] = launch;
  assign send[1] = launch & tx_busy_o[1] & slot_tx_en_i[1];
  assign cap     = {N_SLOTS{rx_frame_i & if_en_i}} & slot_rx_en_i & rx_tag_i;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    ac97_regacc_txslot u_tx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (~if_en_i),
      .load_i (ld[g]),
      .wdata_i(wdat[g]),
      .send_i (send[g]),
      .hold_o (hold[g]),
      .busy_o (tx_busy_o[g])
    );
    ac97_regacc_rxslot u_rx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (~if_en_i),
      .cap_i  (cap[g]),
      .din_i  (rxd[g]),
      .rd_i   (rd[g]),
      .data_o (capd[g]),
      .valid_o(rx_valid_o[g])
    );
  end

  assign sts_addr_o = capd[0];
  assign sts_data_o = capd[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_tag_o   <= '0;
      tx_codec_o <= '0;
      tx_slot1_o <= '0;
      tx_slot2_o <= '0;
    end else if (frame_start_i) begin
      tx_tag_o   <= send;
      tx_codec_o <= codec_sel_i;
      tx_slot1_o <= send[0] ? hold[0] : '0;
      tx_slot2_o <= send[1] ? hold[1] : '0;
    end
  end
endmodule

// File: rtl/ac97_regacc_chk.sv
module ac97_regacc_chk
  import ac97_regacc_pkg::*;
#(
  parameter int CID_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              if_en_i,
  input logic [N_SLOTS-1:0] slot_tx_en_i,
  input logic [N_SLOTS-1:0] slot_rx_en_i,
  input logic              cmd_addr_we_i,
  input logic              sts_addr_re_i,
  input logic [SLOT_W-1:0] sts_addr_o,
  input logic [N_SLOTS-1:0] tx_busy_o,
  input logic [N_SLOTS-1:0] rx_valid_o,
  input logic              frame_start_i,
  input logic [N_SLOTS-1:0] tx_tag_o,
  input logic [CID_W-1:0]  codec_sel_i,
  input logic [CID_W-1:0]  tx_codec_o,
  input logic              rx_frame_i,
  input logic [N_SLOTS-1:0] rx_tag_i,
  input logic [SLOT_W-1:0] rx_slot1_i
);
  AST_LAUNCH_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && if_en_i && tx_busy_o[0] && slot_tx_en_i[0] && !cmd_addr_we_i
      |=> !tx_busy_o[0] && tx_tag_o[0]); // R3
  AST_SLOT2_NEEDS_SLOT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tag_o[1] |-> tx_tag_o[0]); // R4
  AST_TX_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && !slot_tx_en_i[0] |=> !tx_tag_o[0]); // R5
  AST_TX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(tx_tag_o) && $stable(tx_codec_o)); // R6
  AST_RX_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frame_i && if_en_i && slot_rx_en_i[0] && rx_tag_i[0]
      |=> rx_valid_o[0] && sts_addr_o == $past(rx_slot1_i)); // R7
  AST_READ_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_addr_re_i && !(rx_frame_i && slot_rx_en_i[0] && rx_tag_i[0]) |=> !rx_valid_o[0]); // R9
  AST_DISABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !if_en_i |=> tx_busy_o == '0 && rx_valid_o == '0); // R12
  AST_CODEC_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> tx_codec_o == $past(codec_sel_i)); // R13
endmodule

bind ac97_regacc ac97_regacc_chk #(.CID_W(CID_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .if_en_i      (if_en_i),
  .slot_tx_en_i (slot_tx_en_i),
  .slot_rx_en_i (slot_rx_en_i),
  .cmd_addr_we_i(cmd_addr_we_i),
  .sts_addr_re_i(sts_addr_re_i),
  .sts_addr_o   (sts_addr_o),
  .tx_busy_o    (tx_busy_o),
  .rx_valid_o   (rx_valid_o),
  .frame_start_i(frame_start_i),
  .tx_tag_o     (tx_tag_o),
  .codec_sel_i  (codec_sel_i),
  .tx_codec_o   (tx_codec_o),
  .rx_frame_i   (rx_frame_i),
  .rx_tag_i     (rx_tag_i),
  .rx_slot1_i   (rx_slot1_i)
);

// File: tb/ac97_regacc_test.sv
module ac97_regacc_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic if_en = 1'b0;
  logic [1:0] sel = '0, te = '0, re = '0;
  logic wa = 0, wd = 0, ra = 0, rdd = 0, frm = 0, rxf = 0;
  logic [19:0] wad = '0, wdd = '0, rx1 = '0, rx2 = '0;
  logic [1:0] rtag = '0;
  logic [19:0] sts_a, sts_d, t1, t2;
  logic [1:0] busy, vld, ttag, tcid;

  int n_cmp = 0, n_bad = 0;
  logic chk_on = 1'b0;

  // model state
  logic [19:0] m_h1 = '0, m_h2 = '0, m_sa = '0, m_sd = '0, m_t1 = '0, m_t2 = '0;
  logic m_b1 = 0, m_b2 = 0, m_v1 = 0, m_v2 = 0, m_tv1 = 0, m_tv2 = 0;
  logic [1:0] m_cid = '0;
  logic l1, l2, c1, c2;

  always #(CLK_PERIOD/2) clk = ~clk;

  ac97_regacc uut (
    .clk_i(clk), .rst_ni(rst_n), .if_en_i(if_en), .codec_sel_i(sel),
    .slot_tx_en_i(te), .slot_rx_en_i(re),
    .cmd_addr_we_i(wa), .cmd_addr_i(wad), .cmd_data_we_i(wd), .cmd_data_i(wdd),
    .sts_addr_re_i(ra), .sts_data_re_i(rdd), .sts_addr_o(sts_a), .sts_data_o(sts_d),
    .tx_busy_o(busy), .rx_valid_o(vld), .frame_start_i(frm), .tx_tag_o(ttag),
    .tx_codec_o(tcid), .tx_slot1_o(t1), .tx_slot2_o(t2),
    .rx_frame_i(rxf), .rx_tag_i(rtag), .rx_slot1_i(rx1), .rx_slot2_i(rx2)
  );

  // behavioural reference, advanced on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_h1 = '0; m_h2 = '0; m_sa = '0; m_sd = '0; m_t1 = '0; m_t2 = '0;
      m_b1 = 0; m_b2 = 0; m_v1 = 0; m_v2 = 0; m_tv1 = 0; m_tv2 = 0; m_cid = '0;
    end else begin
      l1 = frm && if_en && m_b1 && te[0];
      l2 = l1 && m_b2 && te[1];
      if (frm) begin
        m_tv1 = l1; m_tv2 = l2; m_cid = sel;
        m_t1 = l1 ? m_h1 : 20'h0;
        m_t2 = l2 ? m_h2 : 20'h0;
      end
      if (!if_en) m_b1 = 0; else if (wa) m_b1 = 1; else if (l1) m_b1 = 0;
      if (!if_en) m_b2 = 0; else if (wd) m_b2 = 1; else if (l2) m_b2 = 0;
      if (wa) m_h1 = wad;
      if (wd) m_h2 = wdd;
      c1 = rxf && if_en && re[0] && rtag[0];
      c2 = rxf && if_en && re[1] && rtag[1];
      if (c1) m_sa = rx1;
      if (c2) m_sd = rx2;
      if (!if_en) m_v1 = 0; else if (c1) m_v1 = 1; else if (ra) m_v1 = 0;
      if (!if_en) m_v2 = 0; else if (c2) m_v2 = 1; else if (rdd) m_v2 = 0;
    end
  end

  task automatic cmp(string req, string nm, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %h expected %h", req, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      cmp("R1 R2 R5 R11 R12", "busy1", 32'(busy[0]), 32'(m_b1));
      cmp("R2 R4 R12", "busy2", 32'(busy[1]), 32'(m_b2));
      cmp("R3 R5 R6", "tag1", 32'(ttag[0]), 32'(m_tv1));
      cmp("R4 R6", "tag2", 32'(ttag[1]), 32'(m_tv2));
      cmp("R3 R6 R11", "slot1", 32'(t1), 32'(m_t1));
      cmp("R3 R4 R6", "slot2", 32'(t2), 32'(m_t2));
      cmp("R13", "codec", 32'(tcid), 32'(m_cid));
      cmp("R7 R8 R9 R12", "valid1", 32'(vld[0]), 32'(m_v1));
      cmp("R7 R8 R9 R12", "valid2", 32'(vld[1]), 32'(m_v2));
      cmp("R7 R8 R10", "sts_addr", 32'(sts_a), 32'(m_sa));
      cmp("R7 R8 R10", "sts_data", 32'(sts_d), 32'(m_sd));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_pulse();
    frm = 1; tick(); frm = 0; tick(2);
  endtask

  task automatic load_cmd(logic [19:0] a, logic [19:0] d, logic with_data);
    if (with_data) begin wd = 1; wdd = d; tick(); wd = 0; end
    wa = 1; wad = a; tick(); wa = 0;
  endtask

  task automatic rx_frame(logic [1:0] tg, logic [19:0] a, logic [19:0] d);
    rxf = 1; rtag = tg; rx1 = a; rx2 = d; tick(); rxf = 0; rtag = '0; tick();
  endtask

  initial begin
    #1 rst_n = 1'b0;
    @(posedge clk); #1 chk_on = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    if_en = 1; te = 2'b11; re = 2'b11; sel = 2'd2;
    tick();
    // R3 R4: register write, data first then index 0x02
    load_cmd({1'b0, 7'h02, 12'h0}, {16'hABCD, 4'h0}, 1);
    tick(2);
    frame_pulse();
    frame_pulse();
    // R3: read request, bit 19 set, index 0x7C
    load_cmd({1'b1, 7'h7C, 12'h0}, '0, 0);
    frame_pulse();
    // R4: slot 2 gated; stays busy, slot 2 alone never sent
    te = 2'b01;
    load_cmd({1'b0, 7'h18, 12'h0}, {16'h1234, 4'h0}, 1);
    frame_pulse();
    te = 2'b11;
    frame_pulse();
    load_cmd({1'b0, 7'h1A, 12'h0}, '0, 0);
    frame_pulse();
    // R5: slot 1 gated
    te = 2'b10;
    load_cmd({1'b0, 7'h26, 12'h0}, {16'h5555, 4'h0}, 1);
    frame_pulse();
    te = 2'b11;
    frame_pulse();
    // R11: load on the sending edge
    load_cmd({1'b0, 7'h2C, 12'h0}, '0, 0);
    wa = 1; wad = {1'b0, 7'h2E, 12'h0}; frm = 1; tick(); wa = 0; frm = 0; tick(2);
    frame_pulse();
    // R7 R9 R10: capture, read, overwrite
    rx_frame(2'b11, {1'b0, 7'h7C, 12'h0}, {16'h6A90, 4'h0});
    ra = 1; tick(); ra = 0; tick();
    rx_frame(2'b10, 20'h11111, {16'hBEEF, 4'h0});
    rx_frame(2'b10, 20'h22222, {16'hCAFE, 4'h0});
    rdd = 1; tick(); rdd = 0; tick();
    // R8: tag low or receive disabled
    rx_frame(2'b00, 20'h33333, 20'h44444);
    re = 2'b10;
    rx_frame(2'b11, 20'h55555, 20'h66666);
    re = 2'b11;
    // R9: capture and read in the same cycle
    ra = 1; rxf = 1; rtag = 2'b01; rx1 = 20'h77777; tick(); ra = 0; rxf = 0; rtag = '0; tick(2);
    ra = 1; tick(); ra = 0; tick();
    // R13: codec select
    sel = 2'd1; frame_pulse();
    sel = 2'd3; load_cmd({1'b1, 7'h00, 12'h0}, '0, 0); frame_pulse();
    // R12: interface disabled
    load_cmd({1'b0, 7'h02, 12'h0}, {16'h0F0F, 4'h0}, 1);
    rx_frame(2'b11, 20'h88888, 20'h99999);
    if_en = 0; tick(2);
    load_cmd({1'b0, 7'h04, 12'h0}, {16'hF0F0, 4'h0}, 1);
    frame_pulse();
    rx_frame(2'b11, 20'hAAAAA, 20'hBBBBB);
    if_en = 1; tick();
    frame_pulse();
    load_cmd({1'b0, 7'h06, 12'h0}, {16'h0001, 4'h0}, 1);
    frame_pulse();
    tick(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule